// File: doc/BRIEF.md
# Boundary-Scan Data Register with Mixed-Polarity Output Enables

This block is the boundary-scan data register of a small device. It is a single serial chain of cells between the test data input and the test data output. There are three kinds of cell. Input cells sit between the input pads and the core. Output data cells sit between the core and the output pads. Enable cells control whole groups of tristate output drivers. Every cell has two stages: a shift flop that captures and shifts, and an update latch whose value is applied to the pins or to the core while a test instruction is active.

The TAP controller and the instruction register lie outside the block. The block receives their decoded capture, shift and update strobes as one-cycle enables on the test clock. It also receives a 3-bit mode code. In normal and sample modes the cells only observe: the core and the pads are connected straight through. In the external-test and internal-test modes, the update latches drive both the core inputs and the pads. The high-impedance mode floats every driver group, whatever the cells hold.

Enable cells come in two polarities, chosen per group by a parameter bit. A group whose bit is 1 is disabled when its enable value is 1. A group whose bit is 0 is disabled when its enable value is 0.

Top module: `bscan_reg`

## Requirements
- R1: The chain order is fixed. Cell index 0 is nearest `tdi`. Input cells come first: input cell i is at index i. Each group g then occupies NUM_IN+g*(GRP_W+1): its enable cell is at that base, and its data bit b is at base+1+b (this drives pad_out[g*GRP_W+b]). The cell at the highest index feeds `tdo`. A shift moves every cell one index up and loads `tdi` into index 0.
- R2: `tdo` is retimed on the falling clock edge. It changes half a cycle after the rising edge that shifts the chain, and it does not change at the rising edge itself.
- R3: An update latch changes only in a cycle with `update_dr` high, when it loads its cell's shift flop. Capturing or shifting leaves the driven values at the pads and at the core inputs unchanged.
- R4: In mode 0 (normal), mode 1 (sample/preload) and any code above 4, `core_in` equals `pin_in` and `pad_out` equals `core_out`. The enables follow `core_oe_raw` under the group polarity.
- R5: In mode 2 (external test), `pad_out` comes from the output data cells' update latches. `core_in` comes from the input cells' update latches, so that preloaded guard values reach the core.
- R6: In mode 3 (internal test), `core_in` comes from the input cells' update latches. A capture loads `core_out` into the data cells and `core_oe_raw` into the enable cells.
- R7: The drive enable `pad_oe[g]` is 1 when the group's enable value e (cell or core) gives: e==0 for a group with GRP_DIS_ON_ONE[g]=1, and e==1 for a group with GRP_DIS_ON_ONE[g]=0.
- R8: In mode 4 (high impedance), every bit of `pad_oe` is 0, whatever the cells or the core enables hold.
- R9: In modes other than 2, a capture loads `pin_in` into the input cells, `core_out` into the data cells and the raw core enable level into the enable cells. A core that drives a disable-on-one enable high is read back as 1.
- R10: In mode 2, a capture loads `pin_in` into the input cells. The data and enable cells instead capture the values their update latches are driving.
- R11: A synchronous reset clears all shift flops, update latches and `tdo` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test-logic reset |
| mode | input | 3 | Decoded instruction: 0 normal, 1 sample/preload, 2 external test, 3 internal test, 4 high impedance |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| pin_in | input | NUM_IN | Values at the input pads |
| core_out | input | NUM_GRP*GRP_W | Output data from the core |
| core_oe_raw | input | NUM_GRP | Raw enable level from the core, in each group's own polarity |
| tdo | output | 1 | Serial data out, retimed on the falling edge |
| core_in | output | NUM_IN | Values presented to the core inputs |
| pad_out | output | NUM_GRP*GRP_W | Data presented to the output pads |
| pad_oe | output | NUM_GRP | Active-high drive enable for each output group |

## Verification
A shift flop holding a wrong value cannot be seen at once. It shows up only at `tdo`: after a capture, or after the shift that brings that index to the end of the chain, at most CHAIN_LEN cycles later. The bench reads the whole chain back and compares every index. A wrong update latch shows up on `pad_out`, `core_in` or `pad_oe` in the cycle after the update strobe, but only in the drive modes. For this reason each preloaded vector is checked in external test, internal test and high impedance. A latch that moves without an update strobe is caught by shifting new data while those outputs are watched.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [2:0] {
    BS_NORMAL = 3'd0,
    BS_SAMPLE = 3'd1,
    BS_EXTEST = 3'd2,
    BS_INTEST = 3'd3,
    BS_HIGHZ  = 3'd4
  } bs_mode_e;
endpackage

// File: rtl/bsr_cell.sv
// One scan cell: capture/shift stage plus an update stage that holds
// the value applied while a test mode drives the pins or core.
module bsr_cell (
  input  logic clk,
  input  logic rst,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic cap_val,
  input  logic ser_in,
  output logic ser_q,
  output logic upd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ser_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      if (cap_en)        ser_q <= cap_val;
      else if (shift_en) ser_q <= ser_in;
      if (upd_en)        upd_q <= ser_q;
    end
  end
endmodule

// File: rtl/bsr_oe_gate.sv
// Turns one group's enable value into an active-high drive enable.
module bsr_oe_gate #(
  parameter logic DIS_ON_ONE = 1'b1
) (
  input  logic highz,
  input  logic use_cell,
  input  logic cell_val,
  input  logic core_val,
  output logic drive
);
  logic sel;
  always_comb begin
    sel = use_cell ? cell_val : core_val;
    if (highz) drive = 1'b0;
    else       drive = sel ^ DIS_ON_ONE;
  end
endmodule

// File: rtl/bsr_tdo_stage.sv
// Falling-edge retiming of the serial output.
module bsr_tdo_stage (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(negedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/bscan_reg.sv
module bscan_reg
  import bsr_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_GRP = 2,
  parameter int GRP_W   = 3,
  parameter logic [NUM_GRP-1:0] GRP_DIS_ON_ONE = 2'b01
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2:0]               mode,
  input  logic                     capture_dr,
  input  logic                     shift_dr,
  input  logic                     update_dr,
  input  logic                     tdi,
  input  logic [NUM_IN-1:0]        pin_in,
  input  logic [NUM_GRP*GRP_W-1:0] core_out,
  input  logic [NUM_GRP-1:0]       core_oe_raw,
  output logic                     tdo,
  output logic [NUM_IN-1:0]        core_in,
  output logic [NUM_GRP*GRP_W-1:0] pad_out,
  output logic [NUM_GRP-1:0]       pad_oe
);
  localparam int GRP_CELLS = GRP_W + 1;
  localparam int CHAIN_LEN = NUM_IN + NUM_GRP * GRP_CELLS;

  logic [CHAIN_LEN:0]   link;
  logic [CHAIN_LEN-1:0] upd;
  logic ext_mode, drive_mode, hz_mode;

  assign ext_mode   = (mode == BS_EXTEST);
  assign drive_mode = ext_mode || (mode == BS_INTEST);
  assign hz_mode    = (mode == BS_HIGHZ);
  assign link[0]    = tdi;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    bsr_cell u_cell (
      .clk(clk), .rst(rst), .cap_en(capture_dr), .shift_en(shift_dr),
      .upd_en(update_dr), .cap_val(pin_in[i]), .ser_in(link[i]),
      .ser_q(link[i+1]), .upd_q(upd[i])
    );
    assign core_in[i] = drive_mode ? upd[i] : pin_in[i];
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int BASE = NUM_IN + g * GRP_CELLS;

    bsr_cell u_en (
      .clk(clk), .rst(rst), .cap_en(capture_dr), .shift_en(shift_dr),
      .upd_en(update_dr),
      .cap_val(ext_mode ? upd[BASE] : core_oe_raw[g]),
      .ser_in(link[BASE]), .ser_q(link[BASE+1]), .upd_q(upd[BASE])
    );

    bsr_oe_gate #(.DIS_ON_ONE(GRP_DIS_ON_ONE[g])) u_gate (
      .highz(hz_mode), .use_cell(drive_mode), .cell_val(upd[BASE]),
      .core_val(core_oe_raw[g]), .drive(pad_oe[g])
    );

    for (genvar b = 0; b < GRP_W; b++) begin : g_dat
      localparam int IDX = BASE + 1 + b;
      localparam int PIN = g * GRP_W + b;
      bsr_cell u_cell (
        .clk(clk), .rst(rst), .cap_en(capture_dr), .shift_en(shift_dr),
        .upd_en(update_dr),
        .cap_val(ext_mode ? upd[IDX] : core_out[PIN]),
        .ser_in(link[IDX]), .ser_q(link[IDX+1]), .upd_q(upd[IDX])
      );
      assign pad_out[PIN] = drive_mode ? upd[IDX] : core_out[PIN];
    end
  end

  bsr_tdo_stage u_tdo (.clk(clk), .rst(rst), .d(link[CHAIN_LEN]), .q(tdo));
endmodule

// File: rtl/bscan_reg_chk.sv
module bscan_reg_chk #(
  parameter int NUM_IN  = 4,
  parameter int NUM_GRP = 2,
  parameter int GRP_W   = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic [2:0]               mode,
  input logic                     update_dr,
  input logic [NUM_IN-1:0]        pin_in,
  input logic [NUM_GRP*GRP_W-1:0] core_out,
  input logic [NUM_IN-1:0]        core_in,
  input logic [NUM_GRP*GRP_W-1:0] pad_out,
  input logic [NUM_GRP-1:0]       pad_oe
);
  assert_highz_floats_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd4) |-> (pad_oe == '0));

  assert_observe_passthru_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 || mode == 3'd1) |-> (core_in == pin_in && pad_out == core_out));

  assert_extest_pads_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd2 && !update_dr) |=> (mode != 3'd2 || $stable(pad_out)));

  assert_intest_core_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd3 && !update_dr) |=> (mode != 3'd3 || $stable(core_in)));
endmodule

bind bscan_reg bscan_reg_chk #(.NUM_IN(NUM_IN), .NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .update_dr(update_dr), .pin_in(pin_in),
  .core_out(core_out), .core_in(core_in), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/tb_bscan_reg.sv
`timescale 1ns/1ps
module tb_bscan_reg;
  localparam int NI = 4, NG = 2, GW = 3, NO = NG * GW, L = NI + NG * (GW + 1);
  localparam logic [NG-1:0] POL = 2'b01;

  logic clk = 0, rst = 1;
  logic [2:0] mode = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic [NI-1:0] pin_in = 0;
  logic [NO-1:0] core_out = 0;
  logic [NG-1:0] core_oe_raw = 0;
  logic tdo;
  logic [NI-1:0] core_in;
  logic [NO-1:0] pad_out;
  logic [NG-1:0] pad_oe;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  bscan_reg #(.NUM_IN(NI), .NUM_GRP(NG), .GRP_W(GW), .GRP_DIS_ON_ONE(POL)) dut (
    .clk(clk), .rst(rst), .mode(mode), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .pin_in(pin_in), .core_out(core_out),
    .core_oe_raw(core_oe_raw), .tdo(tdo), .core_in(core_in), .pad_out(pad_out),
    .pad_oe(pad_oe));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [L-1:0] pack(logic [NI-1:0] ins, logic [NG-1:0] ens, logic [NO-1:0] d);
    logic [L-1:0] v;
    v[NI-1:0] = ins;
    for (int g = 0; g < NG; g++) begin
      v[NI + g*(GW+1)] = ens[g];
      for (int b = 0; b < GW; b++) v[NI + g*(GW+1) + 1 + b] = d[g*GW + b];
    end
    return v;
  endfunction

  function automatic logic [NG-1:0] drive_of(logic [NG-1:0] ens);
    logic [NG-1:0] r;
    for (int g = 0; g < NG; g++) r[g] = POL[g] ? ~ens[g] : ens[g];
    return r;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic shift_vec(input logic [L-1:0] vin, output logic [L-1:0] vout);
    shift_dr = 1;
    for (int j = 0; j < L; j++) begin
      tdi = vin[L-1-j];
      @(negedge clk); #0.5;
      vout[L-1-j] = tdo;
      @(posedge clk); #1;
    end
    shift_dr = 0;
  endtask

  task automatic capture();
    capture_dr = 1; tick(); capture_dr = 0;
  endtask

  task automatic update();
    update_dr = 1; tick(); update_dr = 0;
  endtask

  task automatic load(input logic [L-1:0] v);
    logic [L-1:0] dummy;
    shift_vec(v, dummy);
    update();
  endtask

  task automatic t_reset();
    pin_in = 4'hA; core_out = 6'h2D; core_oe_raw = 2'b10; mode = 0;
    rst = 1; tick(); tick(); rst = 0; tick();
    check("R11 tdo after reset", tdo, 0);
    check("R4 core_in normal", core_in, 4'hA);
    check("R4 pad_out normal", pad_out, 6'h2D);
    check("R7 pad_oe normal", pad_oe, drive_of(2'b10));
  endtask

  task automatic t_sample();
    logic [L-1:0] got;
    mode = 1; pin_in = 4'h5; core_out = 6'h33; core_oe_raw = 2'b01;
    tick();
    check("R4 sample passthru", {pad_out, core_in}, {6'h33, 4'h5});
    capture();
    shift_vec('0, got);
    check("R9 R1 sample capture", got, pack(4'h5, 2'b01, 6'h33));
  endtask

  task automatic t_extest();
    logic [L-1:0] v, got;
    mode = 1;
    v = pack(4'h9, 2'b10, 6'h1E);
    load(v);
    check("R4 no drive in sample", pad_out, core_out);
    mode = 2; pin_in = 4'h6; tick();
    check("R5 extest pad_out", pad_out, 6'h1E);
    check("R5 extest guard core_in", core_in, 4'h9);
    check("R7 extest oe polarity", pad_oe, drive_of(2'b10));
    shift_vec(pack(4'h0, 2'b01, 6'h21), got);
    check("R3 pads hold during shift", pad_out, 6'h1E);
    check("R1 extest readback", got, v);
    update();
    check("R3 update applies", pad_out, 6'h21);
    check("R7 second polarity", pad_oe, drive_of(2'b01));
    capture();
    shift_vec('0, got);
    check("R10 extest capture", got, pack(4'h6, 2'b01, 6'h21));
  endtask

  task automatic t_polarity();
    for (int e = 0; e < 4; e++) begin
      mode = 1; load(pack(4'h0, e[1:0], 6'h3F));
      mode = 2; tick();
      check("R7 enable combo", pad_oe, drive_of(e[1:0]));
      mode = 4; tick();
      check("R8 highz override", pad_oe, 0);
    end
    core_oe_raw = drive_of(2'b11); mode = 4; tick();
    check("R8 highz over core", pad_oe, 0);
  endtask

  task automatic t_intest();
    logic [L-1:0] got;
    mode = 1; load(pack(4'hC, 2'b01, 6'h0F));
    mode = 3; pin_in = 4'h3; core_out = 6'h2A; core_oe_raw = 2'b11; tick();
    check("R6 intest core_in", core_in, 4'hC);
    capture();
    check("R3 core_in held on capture", core_in, 4'hC);
    shift_vec('0, got);
    check("R6 intest capture core", got, pack(4'h3, 2'b11, 6'h2A));
    check("R9 disable-on-one high seen", got[NI], 1);
  endtask

  task automatic t_tdo_edge();
    logic [L-1:0] got;
    mode = 1;
    shift_vec({1'b1, 1'b0, {(L-2){1'b0}}}, got);
    @(negedge clk); #0.5;
    check("R2 tdo before shift", tdo, 1);
    @(posedge clk); #1;
    shift_dr = 1; tdi = 0; tick(); shift_dr = 0;
    check("R2 tdo held at rising edge", tdo, 1);
    @(negedge clk); #0.5;
    check("R2 tdo after falling edge", tdo, 0);
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_sample();
    t_extest();
    t_polarity();
    t_intest();
    t_tdo_edge();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule